// File: doc/BRIEF.md
# Fractional Clock Divider with Trigger Commit

This block turns a fast reference clock into a one-cycle clock-enable pulse whose average rate is the reference rate divided by a fixed-point divisor. The divisor has an integer part and a fractional part of `FRAC_W` bits. Software does not program the divisor directly. It programs an offset field, and the scaled divisor the hardware uses is the field plus `2^FRAC_W`. A field of zero therefore gives one pulse on every enabled reference cycle, and an all-ones field gives the slowest rate.

A phase accumulator produces the pulses. On every enabled cycle it adds `2^FRAC_W`. When the sum reaches the scaled divisor, it emits a pulse and keeps the remainder. A 2-bit parent-select value travels alongside the divisor to drive an external source multiplexer.

Both settings are written into shadow registers and stay there until a trigger is written. While the request is outstanding, the block shows a busy bit. At the next output-pulse boundary with the gate enabled, the shadow values move into the active registers and busy clears. Because the swap happens at a pulse boundary and the remainder is carried across, no truncated or stretched interval appears at the changeover.

Top module: `fdiv_trig_divider`

## Requirements
- R1: While `rst` is high, at the following clock edge `clk_en_o` and `busy_o` are 0, `sel_o` is 0, the active and shadow fields are 0 and the accumulator is 0.
- R2: The scaled divisor is the active field plus `2^FRAC_W`. With an active field of 0, `clk_en_o` is 1 on every cycle that follows an enabled cycle.
- R3: On each cycle with `gate_en` high, the accumulator adds `2^FRAC_W`. If the sum is at least the scaled divisor, `clk_en_o` is 1 in the next cycle and the accumulator keeps the sum minus the divisor. Otherwise it keeps the sum and `clk_en_o` is 0. The accumulator is always below the scaled divisor.
- R4: Writes through `div_we`/`sel_we` change only the shadow values. `sel_o` and the pulse train are unaffected until a commit.
- R5: A cycle with `trig_wr` high makes `busy_o` read 1 from the next cycle on.
- R6: A commit happens at a clock edge where `busy_o` is 1 and a pulse is generated (gate on, sum reaching the divisor). That same edge loads the shadow field and select into the active registers and clears `busy_o`. The remainder of the old divisor is kept. `busy_o` never falls without `clk_en_o` rising at the same edge.
- R7: While `gate_en` is low, `clk_en_o` is 0, the accumulator holds, and a pending commit waits with `busy_o` at 1.
- R8: An all-ones field gives the largest divisor, `2^FIELD_W - 1 + 2^FRAC_W`. With defaults (4351/256), starting with the accumulator below 256, exactly 10 pulses occur in 170 enabled cycles.
- R9: `div_we` writes only the divisor shadow and `sel_we` writes only the select shadow. A commit after a divisor-only write leaves `sel_o` unchanged.
- R10: If `trig_wr` is high on a commit edge, the commit still happens and `busy_o` stays 1 for a further commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_we | input | 1 | Write strobe for the divisor offset shadow |
| div_field | input | FIELD_W | Divisor offset value (divisor = value + 2^FRAC_W) |
| sel_we | input | 1 | Write strobe for the parent-select shadow |
| sel_field | input | SEL_W | Parent-select value |
| trig_wr | input | 1 | Trigger write: request a commit of the shadow values |
| gate_en | input | 1 | Gate enable; counting and commits only while high |
| clk_en_o | output | 1 | Registered divided clock-enable pulse |
| busy_o | output | 1 | Trigger busy, self-clearing on commit |
| sel_o | output | SEL_W | Active parent select |

## Verification
The bench checks exact pulse counts over windows that start at a known accumulator phase: divide-by-one, a power-of-two ratio, a 1.5 ratio and the all-ones field. An off-by-`2^FRAC_W` divisor or a dropped remainder would miss each count by at least one pulse. A pending trigger is held with the gate off to show it neither commits nor pulses; a design that committed without the gate would clear busy early. A divisor-only write and a trigger held across a commit edge expose a shared write strobe or a lost second request. Random writes, triggers and gate toggles are compared every cycle against a bench model of the requirements.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Per-cycle events shared between the accumulator and trigger control
  typedef struct packed {
    logic wrap;    // a pulse is generated at this edge
    logic commit;  // shadow values move to active at this edge
  } fdiv_evt_t;

endpackage

// File: rtl/fdiv_shadow_regs.sv
module fdiv_shadow_regs #(
  parameter int FIELD_W = 12,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               div_we,
  input  logic [FIELD_W-1:0] div_in,
  input  logic               sel_we,
  input  logic [SEL_W-1:0]   sel_in,
  input  logic               commit,
  output logic [FIELD_W-1:0] act_div,
  output logic [SEL_W-1:0]   act_sel
);

  logic [FIELD_W-1:0] shd_div;
  logic [SEL_W-1:0]   shd_sel;

  // Pending (shadow) side: written freely, never visible to the datapath
  always_ff @(posedge clk) begin
    if (rst) begin
      shd_div <= '0;
      shd_sel <= '0;
    end else begin
      if (div_we) shd_div <= div_in;
      if (sel_we) shd_sel <= sel_in;
    end
  end

  // Live side: updated only by a commit
  always_ff @(posedge clk) begin
    if (rst) begin
      act_div <= '0;
      act_sel <= '0;
    end else if (commit) begin
      act_div <= shd_div;
      act_sel <= shd_sel;
    end
  end

endmodule

// File: rtl/fdiv_trigger_ctrl.sv
module fdiv_trigger_ctrl
  import fdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      trig_wr,
  input  logic      wrap,
  output logic      busy_q,
  output fdiv_evt_t evt
);

  always_comb begin
    evt.wrap   = wrap;
    evt.commit = busy_q & wrap;
  end

  // A new request wins over the clear of the one being committed
  always_ff @(posedge clk) begin
    if (rst)          busy_q <= 1'b0;
    else if (trig_wr) busy_q <= 1'b1;
    else if (evt.commit) busy_q <= 1'b0;
  end

endmodule

// File: rtl/fdiv_phase_acc.sv
module fdiv_phase_acc
  import fdiv_pkg::*;
#(
  parameter  int FRAC_W  = 8,
  parameter  int FIELD_W = 12,
  localparam int DIV_W   = max_int(FIELD_W, FRAC_W) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               gate_en,
  input  logic [FIELD_W-1:0] act_div,
  output logic               wrap,
  output logic               pulse_q,
  output logic [DIV_W-1:0]   acc_q
);

  localparam int SUM_W = DIV_W + 1;
  localparam logic [SUM_W-1:0] STEP = {{(SUM_W-1){1'b0}}, 1'b1} << FRAC_W;

  logic [SUM_W-1:0] scaled_div;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] rem;
  logic [DIV_W-1:0] acc_d;

  always_comb begin
    scaled_div = {{(SUM_W-FIELD_W){1'b0}}, act_div} + STEP;
    sum        = {1'b0, acc_q} + STEP;
    rem        = sum - scaled_div;
    wrap       = gate_en && (sum >= scaled_div);
    if (wrap)         acc_d = rem[DIV_W-1:0];
    else if (gate_en) acc_d = sum[DIV_W-1:0];
    else              acc_d = acc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      pulse_q <= wrap;
    end
  end

endmodule

// File: rtl/fdiv_trig_divider.sv
module fdiv_trig_divider
  import fdiv_pkg::*;
#(
  parameter int FRAC_W  = 8,
  parameter int FIELD_W = 12,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               div_we,
  input  logic [FIELD_W-1:0] div_field,
  input  logic               sel_we,
  input  logic [SEL_W-1:0]   sel_field,
  input  logic               trig_wr,
  input  logic               gate_en,
  output logic               clk_en_o,
  output logic               busy_o,
  output logic [SEL_W-1:0]   sel_o
);

  localparam int DIV_W = max_int(FIELD_W, FRAC_W) + 1;

  logic [FIELD_W-1:0] act_div_w;
  logic [SEL_W-1:0]   act_sel_w;
  logic [DIV_W-1:0]   acc_w;
  logic               wrap_w;
  logic               pulse_w;
  logic               busy_w;
  fdiv_evt_t          evt_w;

  fdiv_phase_acc #(
    .FRAC_W (FRAC_W),
    .FIELD_W(FIELD_W)
  ) u_acc (
    .clk    (clk),
    .rst    (rst),
    .gate_en(gate_en),
    .act_div(act_div_w),
    .wrap   (wrap_w),
    .pulse_q(pulse_w),
    .acc_q  (acc_w)
  );

  fdiv_trigger_ctrl u_trig (
    .clk    (clk),
    .rst    (rst),
    .trig_wr(trig_wr),
    .wrap   (wrap_w),
    .busy_q (busy_w),
    .evt    (evt_w)
  );

  fdiv_shadow_regs #(
    .FIELD_W(FIELD_W),
    .SEL_W  (SEL_W)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .div_we (div_we),
    .div_in (div_field),
    .sel_we (sel_we),
    .sel_in (sel_field),
    .commit (evt_w.commit),
    .act_div(act_div_w),
    .act_sel(act_sel_w)
  );

  assign clk_en_o = pulse_w;
  assign busy_o   = busy_w;
  assign sel_o    = act_sel_w;

endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker
  import fdiv_pkg::*;
#(
  parameter  int FRAC_W  = 8,
  parameter  int FIELD_W = 12,
  parameter  int SEL_W   = 2,
  localparam int DIV_W   = max_int(FIELD_W, FRAC_W) + 1
) (
  input logic               clk,
  input logic               rst,
  input logic               gate_en,
  input logic               trig_wr,
  input logic               clk_en_o,
  input logic               busy_o,
  input logic [SEL_W-1:0]   sel_o,
  input logic [FIELD_W-1:0] act_div,
  input logic [DIV_W-1:0]   acc
);

  localparam logic [DIV_W:0] STEP = {{DIV_W{1'b0}}, 1'b1} << FRAC_W;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!clk_en_o && !busy_o && sel_o == '0));

  a_r3_acc_below_div: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, acc} < ({{(DIV_W+1-FIELD_W){1'b0}}, act_div} + STEP)));

  a_r5_trig_sets_busy: assert property (@(posedge clk) disable iff (rst)
    trig_wr |=> busy_o);

  a_r6_clear_at_pulse: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> clk_en_o);

  a_r4_sel_only_on_commit: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_o) |-> ($past(busy_o) && clk_en_o));

  a_r7_gate_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !gate_en |=> (!clk_en_o && $stable(acc)));

endmodule

bind fdiv_trig_divider fdiv_checker #(
  .FRAC_W (FRAC_W),
  .FIELD_W(FIELD_W),
  .SEL_W  (SEL_W)
) u_fdiv_chk (
  .clk     (clk),
  .rst     (rst),
  .gate_en (gate_en),
  .trig_wr (trig_wr),
  .clk_en_o(clk_en_o),
  .busy_o  (busy_o),
  .sel_o   (sel_o),
  .act_div (act_div_w),
  .acc     (acc_w)
);

// File: tb/test_fdiv_trig_divider.sv
`timescale 1ns/1ps
module test_fdiv_trig_divider;

  localparam int FRAC_W  = 8;
  localparam int FIELD_W = 12;
  localparam int SEL_W   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic div_we = 1'b0, sel_we = 1'b0, trig_wr = 1'b0, gate_en = 1'b0;
  logic [FIELD_W-1:0] div_field = '0;
  logic [SEL_W-1:0]   sel_field = '0;
  logic clk_en_o, busy_o;
  logic [SEL_W-1:0] sel_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  fdiv_trig_divider #(.FRAC_W(FRAC_W), .FIELD_W(FIELD_W), .SEL_W(SEL_W)) i_fdiv_trig_divider (
    .clk(clk), .rst(rst), .div_we(div_we), .div_field(div_field),
    .sel_we(sel_we), .sel_field(sel_field), .trig_wr(trig_wr),
    .gate_en(gate_en), .clk_en_o(clk_en_o), .busy_o(busy_o), .sel_o(sel_o)
  );

  // Reference model built from the requirements
  int m_acc, m_act, m_shd;
  logic [SEL_W-1:0] m_sel, m_shd_sel;
  logic m_busy, m_pulse;

  always @(posedge clk) begin : ref_model
    int step, d, s;
    bit w;
    step = 1 << FRAC_W;
    d = m_act + step;
    s = m_acc + step;
    w = gate_en && (s >= d);
    if (rst) begin
      m_acc <= 0; m_act <= 0; m_shd <= 0;
      m_sel <= '0; m_shd_sel <= '0; m_busy <= 1'b0; m_pulse <= 1'b0;
    end else begin
      m_pulse <= w;
      m_acc   <= w ? s - d : (gate_en ? s : m_acc);
      if (div_we) m_shd <= int'(div_field);
      if (sel_we) m_shd_sel <= sel_field;
      if (m_busy && w) begin
        m_act <= m_shd;
        m_sel <= m_shd_sel;
      end
      if (trig_wr) m_busy <= 1'b1;
      else if (m_busy && w) m_busy <= 1'b0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk({phase, " pulse"}, int'(clk_en_o), int'(m_pulse));
    chk({phase, " busy"},  int'(busy_o),   int'(m_busy));
    chk({phase, " sel"},   int'(sel_o),    int'(m_sel));
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (clk_en_o) cnt++;
    end
  endtask

  task automatic wait_idle(input string tag);
    for (int i = 0; i < 40 && busy_o; i++) tick();
    chk({tag, " busy cleared"}, int'(busy_o), 0);
  endtask

  task automatic do_commit(input int field, input int sel, input string tag);
    div_we = 1'b1; div_field = FIELD_W'(field);
    sel_we = 1'b1; sel_field = SEL_W'(sel);
    tick();
    div_we = 1'b0; sel_we = 1'b0; trig_wr = 1'b1;
    tick();
    trig_wr = 1'b0;
    wait_idle(tag);
  endtask

  initial begin
    int cnt;
    void'($urandom(32'd4242));
    for (int i = 0; i < 3; i++) tick();
    phase = "R1";
    chk("R1 reset pulse", int'(clk_en_o), 0);
    chk("R1 reset busy", int'(busy_o), 0);
    chk("R1 reset sel", int'(sel_o), 0);
    rst = 1'b0; gate_en = 1'b1;
    tick();

    phase = "R2";
    count_pulses(16, cnt);
    chk("R2 field 0 divides by one", cnt, 16);

    phase = "R4";
    div_we = 1'b1; div_field = 12'd256; sel_we = 1'b1; sel_field = 2'd2;
    tick();
    div_we = 1'b0; sel_we = 1'b0;
    count_pulses(12, cnt);
    chk("R4 shadow write leaves rate", cnt, 12);
    chk("R4 shadow write leaves sel", int'(sel_o), 0);

    phase = "R6";
    do_commit(256, 2, "R6");
    chk("R6 sel committed", int'(sel_o), 2);
    phase = "R3";
    count_pulses(20, cnt);
    chk("R3 divide by two", cnt, 10);

    do_commit(128, 1, "R6");
    count_pulses(30, cnt);
    chk("R3 divide by 1.5", cnt, 20);

    phase = "R8";
    do_commit(4095, 3, "R8");
    count_pulses(170, cnt);
    chk("R8 all-ones field", cnt, 10);

    phase = "R7";
    do_commit(0, 0, "R7");
    gate_en = 1'b0;
    sel_we = 1'b1; sel_field = 2'd3;
    tick();
    sel_we = 1'b0; trig_wr = 1'b1;
    tick();
    trig_wr = 1'b0;
    count_pulses(20, cnt);
    chk("R7 no pulses with gate off", cnt, 0);
    chk("R7 trigger still pending", int'(busy_o), 1);
    chk("R7 sel not committed", int'(sel_o), 0);
    gate_en = 1'b1;
    tick();
    chk("R7 commit after gate on", int'(busy_o), 0);
    chk("R7 sel after gate on", int'(sel_o), 3);

    phase = "R9";
    div_we = 1'b1; div_field = 12'd256;
    tick();
    div_we = 1'b0; trig_wr = 1'b1;
    tick();
    trig_wr = 1'b0;
    wait_idle("R9");
    chk("R9 divisor-only write keeps sel", int'(sel_o), 3);
    count_pulses(20, cnt);
    chk("R9 divisor applied", cnt, 10);

    phase = "R10";
    do_commit(0, 1, "R10");
    trig_wr = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick();
      chk("R10 busy held across commits", int'(busy_o), 1);
    end
    trig_wr = 1'b0;
    tick();
    chk("R10 final commit clears busy", int'(busy_o), 0);

    phase = "R5 random";
    for (int i = 0; i < 600; i++) begin
      div_we    = ($urandom % 8) == 0;
      div_field = FIELD_W'(($urandom % 4) == 0 ? $urandom : $urandom % 600);
      sel_we    = ($urandom % 8) == 0;
      sel_field = SEL_W'($urandom);
      trig_wr   = ($urandom % 10) == 0;
      gate_en   = ($urandom % 8) != 0;
      tick();
    end
    div_we = 1'b0; sel_we = 1'b0; trig_wr = 1'b0; gate_en = 1'b1;

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule